// File: doc/BRIEF.md
# Block Cipher Register Front End

This block sits between a 32-bit word-addressed register bus and a 128-bit block cipher core. Software, or a DMA engine, loads up to eight key words, a four-word chaining vector and a mode word. It then pushes four plaintext or ciphertext words into a data window. When the fourth word arrives the block hands a 128-bit block to the core through a start pulse. It waits for the core's done pulse, then holds the four result words in the same window until they have been read out.

The block applies CBC chaining itself. On encrypt, the chaining vector is XORed into the block before the core sees it. On decrypt, the vector is XORed into the core result. The vector then advances to the correct value for the next block. Two DMA request lines, each a packet of four words, follow the input and output ready flags, gated by per-direction enables and a global start bit. A self-timed soft reset clears the whole register file, and a status bit reports when the reset has finished.

Top module: `cipher_reg_frontend`

## Requirements
- R1: Key word i (i = 0..7) is written at byte offset 0x1C - 4*(i XOR 1) and appears on core_key_o bits [32i+31:32i].
- R2: Chaining words k = 0..3 are read/write at 0x20 + 4k. The mode register at 0x30 stores bits 7:2 and reads bit 1 as input-ready and bit 0 as output-ready, ignoring writes to those two bits. The mask register at 0x48 stores bits 6, 5, 3, 2 and 0.
- R3: Offset 0x44 reads the revision, major in bits 7:4 and minor in bits 3:0 (defaults 3 and 1, so 0x31).
- R4: Writing 1 to mask bit 1 starts a soft reset that lasts 8 cycles. During it, mask bit 1 reads 1 and status bit 0 at 0x4C reads 0. Afterwards all registers hold their reset values and status bit 0 reads 1.
- R5: Bus writes made while the soft reset is in progress have no effect.
- R6: Input-ready reads 1 until the fourth data word of a block is written to 0x34..0x40, where word k lands at bits [32k+31:32k]. The block is then sent with a one-cycle core_start_o, but never while output-ready is 1.
- R7: Output-ready rises on the core done pulse. Reads at 0x34 + 4k return result word k, and output-ready clears after the fourth data-window read.
- R8: With mode bit 5 (CBC) clear, the result is the core output unchanged and the chaining words are left untouched.
- R9: CBC encrypt (bit 5 = 1, bit 2 = 1): the core receives input XOR chaining vector, and the core output becomes both the result and the new vector.
- R10: CBC decrypt (bit 5 = 1, bit 2 = 0): the result is core output XOR chaining vector, and the ciphertext input becomes the new vector.
- R11: dma_in_req_o is 1 exactly while mask bit 5 (start), mask bit 2 (input DMA enable) and input-ready are all 1, so it drops right after the fourth data write.
- R12: dma_out_req_o is 1 exactly while mask bit 5, mask bit 3 (output DMA enable) and output-ready are all 1, so it drops right after the fourth data read.
- R13: core_keysize_o follows mode bits 4:3 and core_encrypt_o follows mode bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset, word aligned |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| core_start_o | output | 1 | One-cycle launch of a block |
| core_block_o | output | 128 | Block presented to the core |
| core_key_o | output | 256 | Key words, word i at bits [32i+31:32i] |
| core_keysize_o | output | 2 | Key size code from the mode register |
| core_encrypt_o | output | 1 | Direction, 1 = encrypt |
| core_done_i | input | 1 | One-cycle completion from the core |
| core_result_i | input | 128 | Core output, valid with core_done_i |
| dma_in_req_o | output | 1 | Input packet request |
| dma_out_req_o | output | 1 | Output packet request |

## Verification
The assertions assume that the core raises core_done_i for a single cycle, and only after a start pulse whose block has not yet completed. They also assume that every bus address is word aligned. The bench's core stand-in waits for core_start_o, answers once, two cycles later, with a one-cycle done pulse, and accepts no new start until then. Every bus access the bench makes uses an aligned offset from the register map, and it drives one access per cycle.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
  localparam logic [7:0] ADDR_IV0   = 8'h20;
  localparam logic [7:0] ADDR_MODE  = 8'h30;
  localparam logic [7:0] ADDR_DATA0 = 8'h34;
  localparam logic [7:0] ADDR_REV   = 8'h44;
  localparam logic [7:0] ADDR_MASK  = 8'h48;
  localparam logic [7:0] ADDR_STAT  = 8'h4C;

  // field order equals register bits 7:2
  typedef struct packed {
    logic       cnt_width;
    logic       cnt_mode;
    logic       cbc;
    logic [1:0] key_size;
    logic       encrypt;
  } mode_t;

  typedef struct packed {
    logic idle_req;
    logic start;
    logic dma_out_en;
    logic dma_in_en;
    logic auto_idle;
  } mask_t;
endpackage

// File: rtl/cfe_srst_seq.sv
module cfe_srst_seq #(
  parameter int unsigned SRST_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic active_o
);
  localparam int unsigned CNT_W = $clog2(SRST_CYCLES + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (fire_i && cnt_q == '0)       cnt_q <= CNT_W'(SRST_CYCLES);
    else if (cnt_q != '0)                 cnt_q <= cnt_q - CNT_W'(1);
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/cfe_cfg_regs.sv
module cfe_cfg_regs import cfe_pkg::*; #(
  parameter int unsigned KEY_WORDS = 8,
  parameter int unsigned WORD_W    = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clr_i,
  input  logic                          wr_i,
  input  logic [7:0]                    addr_i,
  input  logic [WORD_W-1:0]             wdata_i,
  output logic [KEY_WORDS*WORD_W-1:0]   key_o,
  output mode_t                         mode_o,
  output mask_t                         mask_o
);
  for (genvar i = 0; i < KEY_WORDS; i++) begin : g_key
    // pairwise swapped, descending from 0x1C
    localparam logic [7:0] KEY_OFF = 8'(32'h1C - 4 * (i ^ 1));
    logic [WORD_W-1:0] key_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          key_q <= '0;
      else if (clr_i)                       key_q <= '0;
      else if (wr_i && addr_i == KEY_OFF)   key_q <= wdata_i;
    end
    assign key_o[i*WORD_W +: WORD_W] = key_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= '0;
      mask_o <= '0;
    end else if (clr_i) begin
      mode_o <= '0;
      mask_o <= '0;
    end else if (wr_i) begin
      if (addr_i == ADDR_MODE) mode_o <= mode_t'(wdata_i[7:2]);
      if (addr_i == ADDR_MASK)
        mask_o <= '{idle_req: wdata_i[6], start: wdata_i[5], dma_out_en: wdata_i[3],
                    dma_in_en: wdata_i[2], auto_idle: wdata_i[0]};
    end
  end
endmodule

// File: rtl/cfe_block_path.sv
module cfe_block_path #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned BLK_WORDS = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            clr_i,
  input  logic                            data_wr_i,
  input  logic                            data_rd_i,
  input  logic                            iv_wr_i,
  input  logic [$clog2(BLK_WORDS)-1:0]    data_idx_i,
  input  logic [$clog2(BLK_WORDS)-1:0]    iv_idx_i,
  input  logic [WORD_W-1:0]               wdata_i,
  input  logic                            cbc_i,
  input  logic                            encrypt_i,
  output logic [WORD_W-1:0]               iv_word_o,
  output logic [WORD_W-1:0]               out_word_o,
  output logic                            in_ready_o,
  output logic                            out_ready_o,
  output logic                            core_start_o,
  output logic [BLK_WORDS*WORD_W-1:0]     core_block_o,
  input  logic                            core_done_i,
  input  logic [BLK_WORDS*WORD_W-1:0]     core_result_i
);
  localparam int unsigned CNT_W = $clog2(BLK_WORDS + 1);
  localparam int unsigned IDX_W = $clog2(BLK_WORDS);
  localparam int unsigned BLK_W = BLK_WORDS * WORD_W;

  logic [BLK_WORDS-1:0][WORD_W-1:0] in_q, iv_q, out_q;
  logic [BLK_W-1:0] held_q, blk_q;
  logic [CNT_W-1:0] in_cnt_q;
  logic [IDX_W-1:0] rd_cnt_q;
  logic busy_q, out_rdy_q, start_q, m_cbc_q, m_enc_q;
  logic in_full, launch, finish;

  assign in_full = (in_cnt_q == CNT_W'(BLK_WORDS));
  assign launch  = in_full && !busy_q && !out_rdy_q;
  assign finish  = busy_q && core_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q <= '0; iv_q <= '0; out_q <= '0; held_q <= '0; blk_q <= '0;
      in_cnt_q <= '0; rd_cnt_q <= '0; busy_q <= 1'b0; out_rdy_q <= 1'b0;
      start_q <= 1'b0; m_cbc_q <= 1'b0; m_enc_q <= 1'b0;
    end else if (clr_i) begin
      in_q <= '0; iv_q <= '0; out_q <= '0; held_q <= '0; blk_q <= '0;
      in_cnt_q <= '0; rd_cnt_q <= '0; busy_q <= 1'b0; out_rdy_q <= 1'b0;
      start_q <= 1'b0; m_cbc_q <= 1'b0; m_enc_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (data_wr_i && !in_full) begin
        in_q[data_idx_i] <= wdata_i;
        in_cnt_q         <= in_cnt_q + CNT_W'(1);
      end
      if (iv_wr_i) iv_q[iv_idx_i] <= wdata_i;
      if (launch) begin
        start_q  <= 1'b1;
        blk_q    <= (cbc_i && encrypt_i) ? (in_q ^ iv_q) : in_q;
        held_q   <= in_q;
        busy_q   <= 1'b1;
        m_cbc_q  <= cbc_i;
        m_enc_q  <= encrypt_i;
        in_cnt_q <= '0;
      end
      // chaining update overrides a same-cycle bus write to the vector
      if (finish) begin
        busy_q    <= 1'b0;
        out_rdy_q <= 1'b1;
        rd_cnt_q  <= '0;
        if (m_cbc_q && m_enc_q) begin
          out_q <= core_result_i;
          iv_q  <= core_result_i;
        end else if (m_cbc_q) begin
          out_q <= core_result_i ^ iv_q;
          iv_q  <= held_q;
        end else begin
          out_q <= core_result_i;
        end
      end
      if (data_rd_i && out_rdy_q) begin
        if (rd_cnt_q == IDX_W'(BLK_WORDS - 1)) begin
          out_rdy_q <= 1'b0;
          rd_cnt_q  <= '0;
        end else begin
          rd_cnt_q <= rd_cnt_q + IDX_W'(1);
        end
      end
    end
  end

  assign iv_word_o    = iv_q[iv_idx_i];
  assign out_word_o   = out_q[data_idx_i];
  assign in_ready_o   = !in_full;
  assign out_ready_o  = out_rdy_q;
  assign core_start_o = start_q;
  assign core_block_o = blk_q;
endmodule

// File: rtl/cipher_reg_frontend.sv
module cipher_reg_frontend import cfe_pkg::*; #(
  parameter int unsigned KEY_WORDS   = 8,
  parameter int unsigned BLK_WORDS   = 4,
  parameter int unsigned SRST_CYCLES = 8,
  parameter logic [3:0]  REV_MAJOR   = 4'd3,
  parameter logic [3:0]  REV_MINOR   = 4'd1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bus_req_i,
  input  logic         bus_we_i,
  input  logic [7:0]   bus_addr_i,
  input  logic [31:0]  bus_wdata_i,
  output logic [31:0]  bus_rdata_o,
  output logic         core_start_o,
  output logic [127:0] core_block_o,
  output logic [255:0] core_key_o,
  output logic [1:0]   core_keysize_o,
  output logic         core_encrypt_o,
  input  logic         core_done_i,
  input  logic [127:0] core_result_i,
  output logic         dma_in_req_o,
  output logic         dma_out_req_o
);
  localparam int unsigned WORD_W = 32;
  localparam int unsigned IDX_W  = $clog2(BLK_WORDS);
  localparam int unsigned SPAN   = 4 * BLK_WORDS;

  logic srst_active, srst_fire, clr, wr_en, rd_en;
  logic iv_hit, data_hit, in_ready, out_ready;
  logic [7:0] data_off, iv_off;
  logic [IDX_W-1:0] data_idx, iv_idx;
  logic [WORD_W-1:0] iv_word, out_word;
  logic [KEY_WORDS*WORD_W-1:0] key_flat;
  mode_t mode;
  mask_t mask;

  assign wr_en     = bus_req_i && bus_we_i && !srst_active;
  assign rd_en     = bus_req_i && !bus_we_i && !srst_active;
  assign srst_fire = wr_en && bus_addr_i == ADDR_MASK && bus_wdata_i[1];
  assign clr       = srst_fire || srst_active;

  assign data_off = bus_addr_i - ADDR_DATA0;
  assign iv_off   = bus_addr_i - ADDR_IV0;
  assign data_hit = (bus_addr_i >= ADDR_DATA0) && (data_off < 8'(SPAN));
  assign iv_hit   = (bus_addr_i >= ADDR_IV0) && (iv_off < 8'(SPAN));
  assign data_idx = data_off[IDX_W+1:2];
  assign iv_idx   = iv_off[IDX_W+1:2];

  cfe_srst_seq #(.SRST_CYCLES(SRST_CYCLES)) u_srst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (srst_fire),
    .active_o (srst_active)
  );

  cfe_cfg_regs #(.KEY_WORDS(KEY_WORDS), .WORD_W(WORD_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .wr_i    (wr_en),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .key_o   (key_flat),
    .mode_o  (mode),
    .mask_o  (mask)
  );

  cfe_block_path #(.WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS)) u_blk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clr_i         (clr),
    .data_wr_i     (wr_en && data_hit),
    .data_rd_i     (rd_en && data_hit),
    .iv_wr_i       (wr_en && iv_hit),
    .data_idx_i    (data_idx),
    .iv_idx_i      (iv_idx),
    .wdata_i       (bus_wdata_i),
    .cbc_i         (mode.cbc),
    .encrypt_i     (mode.encrypt),
    .iv_word_o     (iv_word),
    .out_word_o    (out_word),
    .in_ready_o    (in_ready),
    .out_ready_o   (out_ready),
    .core_start_o  (core_start_o),
    .core_block_o  (core_block_o),
    .core_done_i   (core_done_i),
    .core_result_i (core_result_i)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (iv_hit)                        bus_rdata_o = iv_word;
    else if (data_hit)                 bus_rdata_o = out_word;
    else if (bus_addr_i == ADDR_MODE)  bus_rdata_o = {24'b0, mode, in_ready, out_ready};
    else if (bus_addr_i == ADDR_REV)   bus_rdata_o = {24'b0, REV_MAJOR, REV_MINOR};
    else if (bus_addr_i == ADDR_MASK)
      bus_rdata_o = {25'b0, mask.idle_req, mask.start, 1'b0, mask.dma_out_en,
                     mask.dma_in_en, srst_active, mask.auto_idle};
    else if (bus_addr_i == ADDR_STAT)  bus_rdata_o = {31'b0, !srst_active};
  end

  assign core_key_o     = key_flat;
  assign core_keysize_o = mode.key_size;
  assign core_encrypt_o = mode.encrypt;
  assign dma_in_req_o   = mask.start && mask.dma_in_en && in_ready;
  assign dma_out_req_o  = mask.start && mask.dma_out_en && out_ready;
endmodule

// File: rtl/cfe_checker.sv
module cfe_checker #(
  parameter int unsigned SRST_CYCLES = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         core_start_o,
  input logic         core_done_i,
  input logic         out_ready,
  input logic         srst_active,
  input logic [255:0] core_key_o,
  input logic         dma_out_req_o,
  input logic         dma_in_req_o,
  input logic         in_ready
);
  int unsigned act_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          act_cnt <= 0;
    else if (srst_active) act_cnt <= act_cnt + 1;
    else                  act_cnt <= 0;
  end

  a_r4_srst_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(srst_active) |-> act_cnt == SRST_CYCLES);

  a_r5_key_held_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_active && $past(srst_active) |-> core_key_o == '0);

  a_r6_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_start_o |=> !core_start_o);

  a_r6_no_launch_on_full_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_start_o) |-> !$past(out_ready));

  a_r7_ready_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_ready) |-> $past(core_done_i));

  a_r12_out_req_needs_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_out_req_o |-> out_ready);

  a_r11_in_req_needs_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_in_req_o |-> in_ready);
endmodule

bind cipher_reg_frontend cfe_checker #(.SRST_CYCLES(SRST_CYCLES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .core_start_o  (core_start_o),
  .core_done_i   (core_done_i),
  .out_ready     (out_ready),
  .srst_active   (srst_active),
  .core_key_o    (core_key_o),
  .dma_out_req_o (dma_out_req_o),
  .dma_in_req_o  (dma_in_req_o),
  .in_ready      (in_ready)
);

// File: tb/cipher_reg_frontend_tb.sv
module cipher_reg_frontend_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_req = 0, bus_we = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic core_start, core_enc, core_done = 0, dma_in, dma_out;
  logic [127:0] core_block, core_res = 0;
  logic [255:0] core_key;
  logic [1:0] core_ks;
  int tests = 0, fails = 0, starts = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cipher_reg_frontend u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(bus_req), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .core_start_o(core_start), .core_block_o(core_block), .core_key_o(core_key),
    .core_keysize_o(core_ks), .core_encrypt_o(core_enc), .core_done_i(core_done),
    .core_result_i(core_res), .dma_in_req_o(dma_in), .dma_out_req_o(dma_out)
  );

  function automatic logic [127:0] core_fn(logic [127:0] x, logic [255:0] k);
    return {x[95:0], x[127:96]} ^ k[127:0];
  endfunction

  // core stand-in
  initial forever begin
    @(negedge clk);
    if (core_start) begin
      logic [127:0] b;
      b = core_block;
      starts++;
      repeat (2) @(negedge clk);
      core_done = 1'b1;
      core_res  = core_fn(b, core_key);
      @(negedge clk);
      core_done = 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_req = 0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic put_block(input logic [127:0] b);
    for (int k = 0; k < 4; k++) wr(8'h34 + 8'(4 * k), b[32*k +: 32]);
  endtask

  task automatic get_block(output logic [127:0] b);
    for (int k = 0; k < 4; k++) begin
      logic [31:0] w;
      rd(8'h34 + 8'(4 * k), w);
      b[32*k +: 32] = w;
    end
  endtask

  task automatic wait_out(input string tag);
    logic [31:0] d = 0;
    for (int i = 0; i < 60; i++) begin
      peek(8'h30, d);
      if (d[0]) break;
      @(negedge clk);
    end
    chk(tag, {127'b0, d[0]}, 128'd1);
  endtask

  // {cbc, encrypt, data}
  localparam logic [129:0] VEC [6] = '{
    {2'b01, 128'h00112233_44556677_8899AABB_CCDDEEFF},
    {2'b00, 128'hDEADBEEF_01234567_89ABCDEF_FEEDFACE},
    {2'b11, 128'h11111111_22222222_33333333_44444444},
    {2'b11, 128'h0F0F0F0F_F0F0F0F0_AAAA5555_5555AAAA},
    {2'b10, 128'hCAFEBABE_0BADF00D_13579BDF_2468ACE0},
    {2'b10, 128'h76543210_FEDCBA98_00000001_80000000}
  };

  initial begin
    logic [31:0] d;
    logic [255:0] bkey;
    logic [127:0] biv, o, ex;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    peek(8'h30, d); chk("R6 reset mode/in_ready", 128'(d), 128'h2);
    peek(8'h4C, d); chk("R4 reset status", 128'(d), 128'h1);
    peek(8'h48, d); chk("R2 reset mask", 128'(d), 128'h0);
    peek(8'h44, d); chk("R3 revision", 128'(d), 128'h31);
    chk("R11 R12 reset dma", {126'b0, dma_in, dma_out}, 128'h0);

    // R1 key placement
    for (int i = 0; i < 8; i++) begin
      bkey[32*i +: 32] = 32'h1000_0000 + 32'h0101_0101 * i;
      wr(8'h1C - 8'(4 * (i ^ 1)), bkey[32*i +: 32]);
    end
    chk("R1 key words", core_key[127:0], bkey[127:0]);
    chk("R1 key words hi", core_key[255:128], bkey[255:128]);

    // R2 mode storage, R13 core controls
    wr(8'h30, 32'hFF);
    peek(8'h30, d); chk("R2 mode readback", 128'(d), 128'hFE);
    chk("R13 keysize/encrypt", {125'b0, core_ks, core_enc}, 128'h7);
    wr(8'h30, 32'h10);
    chk("R13 keysize/decrypt", {125'b0, core_ks, core_enc}, 128'h4);

    biv = 128'hA3A2A1A0_B3B2B1B0_C3C2C1C0_D3D2D1D0;
    for (int k = 0; k < 4; k++) wr(8'h20 + 8'(4 * k), biv[32*k +: 32]);
    for (int k = 0; k < 4; k++) begin
      rd(8'h20 + 8'(4 * k), d); chk("R2 iv readback", 128'(d), 128'(biv[32*k +: 32]));
    end

    // table of vectors
    for (int v = 0; v < 6; v++) begin
      logic cbc, enc;
      logic [127:0] din;
      cbc = VEC[v][129]; enc = VEC[v][128]; din = VEC[v][127:0];
      wr(8'h30, {26'b0, cbc, 2'b11, enc, 2'b00});
      if (!cbc)     ex = core_fn(din, bkey);
      else if (enc) begin ex = core_fn(din ^ biv, bkey); biv = ex; end
      else          begin ex = core_fn(din, bkey) ^ biv; biv = din; end
      put_block(din);
      wait_out("R7 out_ready rises");
      get_block(o);
      chk(!cbc ? "R8 ecb result" : enc ? "R9 cbc enc result" : "R10 cbc dec result", o, ex);
      for (int k = 0; k < 4; k++) begin
        rd(8'h20 + 8'(4 * k), d);
        chk(!cbc ? "R8 iv untouched" : enc ? "R9 iv update" : "R10 iv update",
            128'(d), 128'(biv[32*k +: 32]));
      end
    end

    // R6/R7 hold off launch while output unread
    wr(8'h30, 32'h1C);
    put_block(128'h1);
    wait_out("R7 out_ready A");
    put_block(128'h2);
    peek(8'h30, d); chk("R6 in_ready low when full", 128'(d[1]), 128'h0);
    begin
      int s0;
      s0 = starts;
      repeat (10) @(negedge clk);
      chk("R6 no launch while out_ready", 128'(starts), 128'(s0));
      get_block(o);
      chk("R7 block A result", o, core_fn(128'h1, bkey));
      peek(8'h30, d); chk("R7 out_ready clears", 128'(d[0]), 128'h0);
      wait_out("R7 out_ready B");
      chk("R6 launch after drain", 128'(starts), 128'(s0 + 1));
      get_block(o);
      chk("R7 block B result", o, core_fn(128'h2, bkey));
    end

    // R11 input DMA
    wr(8'h48, 32'h04);
    chk("R11 no start -> no in req", 128'(dma_in), 128'h0);
    wr(8'h48, 32'h24);
    chk("R11 in req asserted", 128'(dma_in), 128'h1);
    for (int k = 0; k < 3; k++) wr(8'h34 + 8'(4 * k), 32'h55 + k);
    chk("R11 in req after 3 writes", 128'(dma_in), 128'h1);
    peek(8'h30, d); chk("R6 in_ready after 3 writes", 128'(d[1]), 128'h1);
    wr(8'h40, 32'h99);
    chk("R11 in req drops on 4th", 128'(dma_in), 128'h0);
    wait_out("R7 out_ready dma");
    chk("R12 no out enable", 128'(dma_out), 128'h0);
    wr(8'h48, 32'h08);
    chk("R12 no start -> no out req", 128'(dma_out), 128'h0);
    wr(8'h48, 32'h28);
    peek(8'h48, d); chk("R2 mask readback", 128'(d), 128'h28);
    chk("R12 out req asserted", 128'(dma_out), 128'h1);
    for (int k = 0; k < 3; k++) rd(8'h34 + 8'(4 * k), d);
    chk("R12 out req after 3 reads", 128'(dma_out), 128'h1);
    rd(8'h40, d);
    chk("R12 out req drops on 4th", 128'(dma_out), 128'h0);

    // R4/R5 soft reset
    wr(8'h48, 32'h2A);
    peek(8'h48, d); chk("R4 srst bit reads 1", 128'(d[1]), 128'h1);
    peek(8'h4C, d); chk("R4 status busy", 128'(d), 128'h0);
    wr(8'h30, 32'h3C);
    wr(8'h18, 32'h12345678);
    repeat (8) @(negedge clk);
    peek(8'h4C, d); chk("R4 status done", 128'(d), 128'h1);
    peek(8'h48, d); chk("R4 mask cleared", 128'(d), 128'h0);
    peek(8'h30, d); chk("R5 mode write ignored", 128'(d), 128'h2);
    chk("R5 key write ignored", core_key[127:0], 128'h0);
    peek(8'h20, d); chk("R4 iv cleared", 128'(d), 128'h0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule